// File: doc/BRIEF.md
# Dual Four-Mode Timer/Event Counter

This block holds two 16-bit up-counters. Each one counts either internal machine-cycle ticks or falling edges on its own count pin. A per-counter gate option lets an external level pin admit or hold counting, which makes pulse-width measurement possible. Each counter has four operating modes: a 13-bit count made of an 8-bit counter behind a 5-bit prescaler, a plain 16-bit count, an 8-bit count that reloads itself from the upper byte, and a split mode. In split mode counter 0 becomes two independent 8-bit counters. If counter 1 is placed in split mode, it simply freezes.

Each counter owns a sticky overflow flag. Every wrap of counter 1 also produces a one-cycle pulse for a serial bit-rate generator. The surrounding logic supplies a tick enable that is high once per machine cycle (oscillator divided by 12). It loads counter bytes through a byte-write port, reads the live counts, and clears the flags with explicit clear strobes.

Top module: `tmrPair`

## Requirements
- R1: After reset both counts read 0, both overflow flags are 0 and the baud pulse is 0.
- R2: With internal source selected, run set and gating off, a counter advances by one on each clock in which `tickEn` is high, and holds when it is low.
- R3: With external source selected, the count pin is sampled only on `tickEn` cycles. A counter advances by one when one sample is 1 and the next sample is 0. A pulse that falls between two samples and is never seen is ignored.
- R4: With `gateEn` set for a counter, that counter advances only while its `gatePin` is high.
- R5: Mode 1 (`modeSel`=1) is a 16-bit count. The step from 0xFFFF goes to 0x0000 and sets that counter's flag.
- R6: Mode 0 (`modeSel`=0): bits 4:0 of the low byte act as a prescaler. When they step from 31 to 0, the high byte advances. The flag sets when the high byte is 0xFF and the prescaler is 31. Low-byte bits 7:5 never change on a count.
- R7: Mode 2 (`modeSel`=2): the low byte counts. On a step from 0xFF it is loaded with the high byte and the flag sets. The high byte never changes on a count.
- R8: With counter 0 in mode 3, its low byte counts with counter 0's source, gate and run bit. Its high byte counts every `tickEn` cycle in which `runEn[1]` is set, and a wrap of that high byte sets flag 1.
- R9: While counter 0 is in mode 3, wraps of counter 1 do not set flag 1.
- R10: Counter 1 in mode 3 holds its value.
- R11: `baudPulse` is high for exactly the cycle that shows counter 1's wrapped value, in any counter-0 mode.
- R12: `wrAddr` selects a byte: 0 is the counter 0 low byte, 1 the counter 0 high byte, 2 the counter 1 low byte, 3 the counter 1 high byte. A write takes effect at the next edge and suppresses every count of that counter in the same cycle.
- R13: `flagClr[i]` clears flag i at the next edge. An overflow in the same cycle wins and leaves the flag set.
- R14: With its run bit low, a counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Machine-cycle tick, one clock per machine cycle |
| cntPin | input | 2 | External count pins, one per counter |
| gatePin | input | 2 | Gate level pins, one per counter |
| runEn | input | 2 | Run bits |
| extSel | input | 2 | 1 = count external edges, 0 = count ticks |
| gateEn | input | 2 | 1 = counting requires the gate pin high |
| modeSel0 | input | 2 | Operating mode of counter 0 |
| modeSel1 | input | 2 | Operating mode of counter 1 |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 2 | Byte select for writes |
| wrData | input | 8 | Write data |
| flagClr | input | 2 | Flag clear strobes |
| count0 | output | 16 | Counter 0 value, high byte on top |
| count1 | output | 16 | Counter 1 value, high byte on top |
| ovfFlag | output | 2 | Overflow flags |
| baudPulse | output | 1 | One-cycle pulse on each counter 1 wrap |

## Verification
Every result is due one clock after the stimulus that causes it. A count step, a flag change and the baud pulse all come from registers loaded at the edge that ends the cycle in which the input, the tick and the sampled pin condition were present. The one exception is edge counting. There the falling pin edge is only seen on the tick after the pin was last sampled high, so the count moves one edge after that later tick. The bench drives inputs just after a falling clock edge and advances a behavioural model at each rising edge. It compares every output at the following falling edge, so each comparison lands exactly one register stage after its cause.

// File: rtl/tmrPkg.sv
package tmrPkg;

  typedef enum logic [1:0] {
    MODE_PRESC  = 2'd0,
    MODE_FULL   = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmrMode_t;

  // strobes from control to datapath, one clock cycle each
  typedef struct packed {
    logic [1:0] cntEn;      // step counter k this cycle
    logic       splitHiEn;  // step counter 0 high byte in split mode
    logic [3:0] wrByte;     // one-hot byte write
  } tmrStrb_t;

endpackage

// File: rtl/tmrCtrl.sv
module tmrCtrl
  import tmrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [1:0] cntPin,
  input  logic [1:0] gatePin,
  input  logic [1:0] runEn,
  input  logic [1:0] extSel,
  input  logic [1:0] gateEn,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  output tmrStrb_t   strb
);

  logic [1:0] cntEnV;
  logic [3:0] wrByteV;
  logic       wrCnt0;

  assign wrByteV = wrEn ? (4'b0001 << wrAddr) : 4'b0000;
  assign wrCnt0  = wrEn & ~wrAddr[1];

  for (genvar k = 0; k < 2; k++) begin : gChan
    logic prevSmp;
    logic fallSeen;
    logic srcHit;
    logic wrHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       prevSmp <= 1'b0;
      else if (tickEn) prevSmp <= cntPin[k];
    end

    assign fallSeen  = tickEn & prevSmp & ~cntPin[k];
    assign srcHit    = extSel[k] ? fallSeen : tickEn;
    assign wrHit     = wrEn & (wrAddr[1] == 1'(k));
    assign cntEnV[k] = runEn[k] & (~gateEn[k] | gatePin[k]) & srcHit & ~wrHit;

    // R4
    gate_block_chk: assert property (@(posedge clk) disable iff (!rstN)
      (gateEn[k] && !gatePin[k]) |-> !strb.cntEn[k]);
  end

  assign strb = '{cntEn:     cntEnV,
                  splitHiEn: tickEn & runEn[1] & ~wrCnt0,
                  wrByte:    wrByteV};

endmodule

// File: rtl/tmrData.sv
module tmrData
  import tmrPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrb_t            strb,
  input  logic [1:0]          modeSel0,
  input  logic [1:0]          modeSel1,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [1:0]          flagClr,
  output logic [2*BYTE_W-1:0] count0,
  output logic [2*BYTE_W-1:0] count1,
  output logic [1:0]          ovfFlag,
  output logic                baudPulse
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ONE_B = BYTE_W'(1);
  localparam logic [PRE_W-1:0]  ONE_P = PRE_W'(1);
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

  tmrMode_t          modeArr [2];
  logic [BYTE_W-1:0] loArr   [2];
  logic [BYTE_W-1:0] hiArr   [2];
  logic [1:0]        wrapArr;
  logic              splitHiWrap;
  logic [1:0]        flagQ;
  logic [1:0]        flagSet;
  logic              baudQ;

  assign modeArr[0] = tmrMode_t'(modeSel0);
  assign modeArr[1] = tmrMode_t'(modeSel1);

  for (genvar k = 0; k < 2; k++) begin : gCnt
    logic [BYTE_W-1:0] lo, hi, nLo, nHi;
    logic              sWrap;
    logic              wrLo, wrHi;
    tmrMode_t          md;

    assign md   = modeArr[k];
    assign wrLo = strb.wrByte[2*k];
    assign wrHi = strb.wrByte[2*k+1];

    always_comb begin
      nLo   = lo;
      nHi   = hi;
      sWrap = 1'b0;
      unique case (md)
        MODE_PRESC: begin
          if (&lo[PRE_W-1:0]) begin
            nLo[PRE_W-1:0] = '0;
            nHi            = hi + ONE_B;
            sWrap          = &hi;
          end else begin
            nLo[PRE_W-1:0] = lo[PRE_W-1:0] + ONE_P;
          end
        end
        MODE_FULL: begin
          {nHi, nLo} = {hi, lo} + ONE_C;
          sWrap      = &{hi, lo};
        end
        MODE_RELOAD: begin
          if (&lo) begin
            nLo   = hi;
            sWrap = 1'b1;
          end else begin
            nLo = lo + ONE_B;
          end
        end
        MODE_SPLIT: begin
          if (k == 0) begin
            nLo   = lo + ONE_B;
            sWrap = &lo;
          end
        end
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              lo <= '0;
      else if (wrLo)          lo <= wrData;
      else if (strb.cntEn[k]) lo <= nLo;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      hi <= '0;
      else if (wrHi)  hi <= wrData;
      else if (k == 0 && md == MODE_SPLIT) begin
        if (strb.splitHiEn) hi <= hi + ONE_B;
      end
      else if (strb.cntEn[k]) hi <= nHi;
    end

    assign loArr[k]   = lo;
    assign hiArr[k]   = hi;
    assign wrapArr[k] = strb.cntEn[k] & sWrap;
  end

  assign splitHiWrap = (modeArr[0] == MODE_SPLIT) & strb.splitHiEn & (&hiArr[0]);
  assign flagSet[0]  = wrapArr[0];
  assign flagSet[1]  = splitHiWrap | (wrapArr[1] & (modeArr[0] != MODE_SPLIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      baudQ <= 1'b0;
    end else begin
      flagQ <= (flagQ & ~flagClr) | flagSet;
      baudQ <= wrapArr[1];
    end
  end

  assign count0    = {hiArr[0], loArr[0]};
  assign count1    = {hiArr[1], loArr[1]};
  assign ovfFlag   = flagQ;
  assign baudPulse = baudQ;

  // R7
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeArr[1] == MODE_RELOAD && !strb.wrByte[3]) |=> $stable(hiArr[1]));

  // R10
  split_c1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeArr[1] == MODE_SPLIT && strb.wrByte[3:2] == 2'b00) |=> $stable(count1));

  // R13
  flag0_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag[0]) |-> $past(flagClr[0]));

  // R13
  flag1_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag[1]) |-> $past(flagClr[1]));

  // R9
  split_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeArr[0] == MODE_SPLIT && !splitHiWrap && !ovfFlag[1]) |=> !ovfFlag[1]);

endmodule

// File: rtl/tmrPair.sv
module tmrPair
  import tmrPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic [1:0]          cntPin,
  input  logic [1:0]          gatePin,
  input  logic [1:0]          runEn,
  input  logic [1:0]          extSel,
  input  logic [1:0]          gateEn,
  input  logic [1:0]          modeSel0,
  input  logic [1:0]          modeSel1,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [1:0]          flagClr,
  output logic [2*BYTE_W-1:0] count0,
  output logic [2*BYTE_W-1:0] count1,
  output logic [1:0]          ovfFlag,
  output logic                baudPulse
);

  tmrStrb_t strb;

  tmrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntPin(cntPin),
    .gatePin(gatePin), .runEn(runEn), .extSel(extSel), .gateEn(gateEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .strb(strb)
  );

  tmrData #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .modeSel0(modeSel0),
    .modeSel1(modeSel1), .wrData(wrData), .flagClr(flagClr),
    .count0(count0), .count1(count1), .ovfFlag(ovfFlag),
    .baudPulse(baudPulse)
  );

endmodule

// File: tb/tmrPair_test.sv
`timescale 1ns/1ps
module tmrPair_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [1:0]  cntPin = '0, gatePin = '0, runEn = '0, extSel = '0, gateEn = '0;
  logic [1:0]  modeSel0 = 2'd1, modeSel1 = 2'd1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  flagClr = '0;
  logic [15:0] count0, count1;
  logic [1:0]  ovfFlag;
  logic        baudPulse;

  int checks = 0, errors = 0;
  bit done = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  tmrPair uut (.*);

  // behavioural reference model
  int mLo[2], mHi[2], mFlag[2], mPrev[2], mBaud;

  function automatic void stepModel(int md, int k, inout int L, inout int H, output bit w);
    w = 0;
    case (md)
      0: if (L % 32 == 31) begin L = L - 31; H = (H + 1) % 256; w = (H == 0); end
         else L = L + 1;
      1: begin int v; v = H * 256 + L + 1; w = (v == 65536); v = v % 65536; H = v / 256; L = v % 256; end
      2: if (L == 255) begin L = H; w = 1; end else L = L + 1;
      default: if (k == 0) begin L = (L + 1) % 256; w = (L == 0); end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLo = '{0, 0}; mHi = '{0, 0}; mFlag = '{0, 0}; mPrev = '{0, 0}; mBaud = 0;
    end else begin
      bit en[2], wrc[2], w0, w1, sw;
      int md[2];
      md[0] = modeSel0; md[1] = modeSel1;
      for (int k = 0; k < 2; k++) begin
        bit fall;
        fall = tickEn && mPrev[k] == 1 && !cntPin[k];
        if (tickEn) mPrev[k] = cntPin[k];
        wrc[k] = wrEn && (wrAddr[1] == k[0]);
        en[k] = runEn[k] && (!gateEn[k] || gatePin[k]) && (extSel[k] ? fall : tickEn) && !wrc[k];
      end
      w0 = 0; w1 = 0; sw = 0;
      if (wrEn) begin
        case (wrAddr)
          2'd0: mLo[0] = wrData;
          2'd1: mHi[0] = wrData;
          2'd2: mLo[1] = wrData;
          default: mHi[1] = wrData;
        endcase
      end
      if (en[0]) stepModel(md[0], 0, mLo[0], mHi[0], w0);
      if (md[0] == 3 && tickEn && runEn[1] && !wrc[0]) begin
        mHi[0] = (mHi[0] + 1) % 256; sw = (mHi[0] == 0);
      end
      if (en[1] && md[1] != 3) stepModel(md[1], 1, mLo[1], mHi[1], w1);
      mFlag[0] = (mFlag[0] && !flagClr[0]) || w0;
      mFlag[1] = (mFlag[1] && !flagClr[1]) || sw || (w1 && md[0] != 3);
      mBaud = w1;
    end
  end

  task automatic compare();
    checks++;
    if (count0 !== 16'(mHi[0] * 256 + mLo[0]) || count1 !== 16'(mHi[1] * 256 + mLo[1]) ||
        ovfFlag !== {mFlag[1][0], mFlag[0][0]} || baudPulse !== mBaud[0]) begin
      errors++;
      $display("FAIL %s model: count0=%h/%h count1=%h/%h flag=%b/%b%b baud=%b/%0d", curReq,
               count0, 16'(mHi[0]*256+mLo[0]), count1, 16'(mHi[1]*256+mLo[1]),
               ovfFlag, mFlag[1][0], mFlag[0][0], baudPulse, mBaud);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      if (rstN) compare();
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrByte(int a, int d);
    wrEn = 1; wrAddr = 2'(a); wrData = 8'(d);
    cyc(1);
    wrEn = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    cyc(1);
    curReq = "R1";
    chk("R1 count0", count0, 0); chk("R1 count1", count1, 0);
    chk("R1 flags", ovfFlag, 0); chk("R1 baud", baudPulse, 0);

    // R2 internal ticks
    curReq = "R2"; runEn = 2'b01; tickEn = 1; cyc(10);
    tickEn = 0; cyc(5); tickEn = 1; cyc(3);
    chk("R2 count0", count0, 13); chk("R2 count1", count1, 0);

    // R14 run low holds
    curReq = "R14"; runEn = 2'b00; cyc(6);
    chk("R14 hold", count0, 13);

    // R3 external falling edges
    curReq = "R3"; runEn = 2'b01; extSel = 2'b01;
    for (int i = 0; i < 5; i++) begin cntPin[0] = 1; cyc(1); cntPin[0] = 0; cyc(1); end
    chk("R3 edges", count0, 18);
    tickEn = 0; cntPin[0] = 1; cyc(1); cntPin[0] = 0; cyc(1); tickEn = 1; cyc(2);
    chk("R3 unsampled pulse ignored", count0, 18);

    // R4 gating
    curReq = "R4"; extSel = 0; gateEn = 2'b01; gatePin = 0; cyc(5);
    chk("R4 gate low", count0, 18);
    gatePin = 2'b01; cyc(4);
    chk("R4 gate high", count0, 22);
    gateEn = 0;

    // R12 byte writes, R5 16-bit wrap
    curReq = "R12"; runEn = 0;
    wrByte(0, 8'hFE); wrByte(1, 8'hFF);
    chk("R12 write", count0, 16'hFFFE);
    curReq = "R5"; runEn = 2'b01; cyc(1);
    chk("R5 ffff", count0, 16'hFFFF); chk("R5 no flag yet", ovfFlag[0], 0);
    cyc(1);
    chk("R5 wrap", count0, 0); chk("R5 flag", ovfFlag[0], 1);
    curReq = "R12"; wrByte(0, 8'h10);
    chk("R12 write blocks count", count0, 16'h0010);

    // R13 clear, and overflow winning over clear
    curReq = "R13"; runEn = 0; flagClr = 2'b01; cyc(1); flagClr = 0;
    chk("R13 clear", ovfFlag[0], 0);
    wrByte(0, 8'hFF); wrByte(1, 8'hFF);
    runEn = 2'b01; flagClr = 2'b01; cyc(1); flagClr = 0;
    chk("R13 set wins", ovfFlag[0], 1);

    // R6 prescaled mode
    curReq = "R6"; runEn = 0; modeSel0 = 0;
    flagClr = 2'b01; cyc(1); flagClr = 0;
    wrByte(0, 8'hFE); wrByte(1, 8'hFF);
    runEn = 2'b01; cyc(1);
    chk("R6 before wrap", count0, 16'hFFFF); chk("R6 no flag", ovfFlag[0], 0);
    cyc(1);
    chk("R6 wrap keeps bits 7:5", count0, 16'h00E0); chk("R6 flag", ovfFlag[0], 1);
    runEn = 0; wrByte(0, 8'h1F); wrByte(1, 8'h05); runEn = 2'b01; cyc(1);
    chk("R6 carry", count0, 16'h0600);

    // R7 reload mode on counter 1, R11 baud pulse
    curReq = "R7"; runEn = 0; modeSel1 = 2;
    flagClr = 2'b11; cyc(1); flagClr = 0;
    wrByte(2, 8'hFE); wrByte(3, 8'hF0);
    runEn = 2'b10; cyc(1);
    chk("R7 step", count1, 16'hF0FF);
    cyc(1);
    chk("R7 reload", count1, 16'hF0F0); chk("R7 flag", ovfFlag[1], 1);
    chk("R11 baud on wrap", baudPulse, 1);
    cyc(1);
    chk("R7 after reload", count1, 16'hF0F1); chk("R11 baud single", baudPulse, 0);

    // R8 split mode, R9 no flag from counter 1
    curReq = "R8"; runEn = 0; modeSel0 = 3; modeSel1 = 1;
    flagClr = 2'b11; cyc(1); flagClr = 0;
    wrByte(0, 8'h00); wrByte(1, 8'hFE); wrByte(2, 8'hFF); wrByte(3, 8'hFF);
    runEn = 2'b11; cyc(1);
    chk("R8 halves", count0, 16'hFF01);
    chk("R9 wrap no flag", ovfFlag[1], 0); chk("R11 baud in split", baudPulse, 1);
    cyc(1);
    chk("R8 high wrap", count0, 16'h0002); chk("R8 flag1", ovfFlag[1], 1);
    chk("R8 flag0 clear", ovfFlag[0], 0);

    // R10 counter 1 frozen
    curReq = "R10"; modeSel1 = 3; cyc(5);
    chk("R10 hold", count1, 16'h0001);

    // mixed traffic against the model
    curReq = "R12";
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin modeSel0 = 2'($urandom); modeSel1 = 2'($urandom); end
      tickEn = ($urandom % 3) != 0;
      cntPin = 2'($urandom); gatePin = 2'($urandom);
      runEn = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
      extSel = (i % 500 < 250) ? 2'b00 : 2'b11;
      gateEn = (i % 1000 < 500) ? 2'b00 : 2'b11;
      wrEn = ($urandom % 16 == 0); wrAddr = 2'($urandom);
      wrData = ($urandom % 2 == 0) ? 8'hFF : 8'($urandom);
      flagClr = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      cyc(1);
    end
    wrEn = 0; flagClr = 0;
    finishRun();
  end

endmodule